// File: doc/BRIEF.md
# Asynchronous Serial Channel Mode and Framing Control

This block holds the operating settings of one asynchronous serial channel and turns them into the framing parameters that its transmitter and receiver use. A 16-bit mode word selects the number of data bits, one or two stop bits, whether parity is used and which parity sense, and enables the transmitter and receiver independently. A separate 17-bit bit-rate word carries an enable and a divisor. Divisor changes are accepted only after the generator's reference has ticked at least twice since the previous accepted change.

A compact serializer and deserializer consume the decoded settings. They exist so that the framing can be checked on real line waveforms: start bit, LSB-first data, optional parity, stop bits, and the parity, framing and break conditions seen on receive. Each frame latches its parameters when it starts, so a mode rewrite never corrupts a character that is already on the line. The channel is shut down by rewriting the mode word with both enable bits cleared.

Top module: `uart_chan_ctrl`

## Requirements
- R1: After reset, txd is 1, tx_ready is 0, and all of the following are 0: chan_tx_on, chan_rx_on, chan_data_bits, brg_on, brg_div, brg_locked and rx_valid.
- R2: Mode word decoding works as follows. Bits 14:11 hold the data-bit count plus one, and only the values 6 to 9 (5 to 8 data bits) are legal. Bits 5:4 must equal 2. If either condition fails, chan_tx_on, chan_rx_on and chan_data_bits are all 0. Bit 10 selects two stop bits (1) or one (0). Bit 9 enables parity. Bit 8 selects even (1) or odd (0) parity. Bit 1 enables the transmitter and bit 0 enables the receiver. With both enable bits cleared the channel is off, but the length still decodes.
- R3: In the bit-rate word, bit 16 is the enable and bits DIV_W:1 hold the divisor. One bit time lasts divisor+1 pulses of brg_src_tick.
- R4: An accepted bit-rate write raises brg_locked. Any further bit-rate write is ignored until brg_src_tick has pulsed twice; brg_locked then falls.
- R5: A transmitted frame is a 0 start bit, then the data bits LSB first, then the parity bit if enabled, then one or two 1 stop bits, after which the line idles at 1. With even parity the data plus parity bit hold an even number of ones; with odd parity they hold an odd number. tx_ready is 1 only when the transmitter is enabled, the bit-rate generator is enabled, and no frame is in progress.
- R6: A frame that has started finishes with the length, parity and stop settings it had at its start, even if the mode word is rewritten during the frame.
- R7: A received frame produces a one-cycle rx_valid pulse. rx_data carries the data bits with the unused upper bits set to 0.
- R8: When parity is enabled and the received parity bit does not match the selected sense, rx_par_err is set with that rx_valid pulse.
- R9: When the first stop bit samples 0 and the character is not a break, rx_frm_err is set.
- R10: A character in which every sampled bit is 0, including the stop bit, is reported with rx_brk set, rx_frm_err and rx_par_err clear, and rx_data 0. The receiver arms again only after the line returns to 1.
- R11: When the receiver is disabled, line activity produces no rx_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Mode word write strobe |
| mode_wdata | input | 16 | Mode word value |
| brg_we | input | 1 | Bit-rate word write strobe |
| brg_wdata | input | 17 | Bit-rate word: enable at bit 16, divisor at DIV_W:1 |
| brg_src_tick | input | 1 | Reference pulse of the bit-rate generator |
| tx_valid | input | 1 | Character offered for transmission |
| tx_data | input | 8 | Character to send |
| tx_ready | output | 1 | Transmitter accepts a character |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line, synchronous to clk |
| rx_valid | output | 1 | One-cycle pulse: a received character is complete |
| rx_data | output | 8 | Received data bits |
| rx_par_err | output | 1 | Parity mismatch on the last character |
| rx_frm_err | output | 1 | Stop bit sampled low on the last character |
| rx_brk | output | 1 | Last character was an all-zero break |
| chan_data_bits | output | 4 | Decoded data-bit count, 0 when the mode is illegal |
| chan_two_stop | output | 1 | Two stop bits selected |
| chan_par_en | output | 1 | Parity enabled |
| chan_par_even | output | 1 | Even parity selected |
| chan_tx_on | output | 1 | Transmitter effectively enabled |
| chan_rx_on | output | 1 | Receiver effectively enabled |
| brg_on | output | 1 | Bit-rate generator enabled |
| brg_div | output | DIV_W | Current divisor |
| brg_locked | output | 1 | Divisor changes currently refused |

## Verification
The bench builds the block with DIV_W = 12 and GUARD_TICKS = 2, and it uses only small odd divisors (3 to 15). That keeps every frame down to a few hundred cycles, so dozens of random characters fit in a short run and both edges of every length, parity and stop setting are covered. With a guard depth of two, the bench can stop brg_src_tick and step it by hand, which shows the lock holding after one pulse and releasing after the second.

// File: rtl/uart_mode_pkg.sv
package uart_mode_pkg;
    localparam int MODE_W     = 16;
    localparam int BRG_W      = 17;
    localparam int BRG_EN_BIT = 16;
    localparam int MAX_DATA   = 8;
    localparam int FRAME_W    = 12;   // start + 8 data + parity + 2 stop
    localparam logic [1:0] OPMODE_ASYNC = 2'd2;

    typedef struct packed {
        logic [3:0] data_bits;
        logic       two_stop;
        logic       par_en;
        logic       par_even;
        logic       tx_on;
        logic       rx_on;
    } chan_cfg_t;

    // Length field holds data bits plus one; legal data lengths are 5..8.
    function automatic chan_cfg_t decode_mode(input logic [MODE_W-1:0] m);
        chan_cfg_t  c;
        logic [3:0] len_fld;
        logic       legal;
        len_fld     = m[14:11];
        legal       = (m[5:4] == OPMODE_ASYNC) && (len_fld >= 4'd6) && (len_fld <= 4'd9);
        c.data_bits = legal ? (len_fld - 4'd1) : 4'd0;
        c.two_stop  = m[10];
        c.par_en    = m[9];
        c.par_even  = m[8];
        c.tx_on     = legal & m[1];
        c.rx_on     = legal & m[0];
        return c;
    endfunction
endpackage

// File: rtl/uart_mode_regs.sv
module uart_mode_regs
    import uart_mode_pkg::*;
#(
    parameter int DIV_W       = 12,
    parameter int GUARD_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              brg_we,
    input  logic [BRG_W-1:0]  brg_wdata,
    input  logic              src_tick,
    output logic [MODE_W-1:0] mode_o,
    output logic              brg_en_o,
    output logic [DIV_W-1:0]  brg_div_o,
    output logic              brg_locked_o
);
    localparam int GW = $clog2(GUARD_TICKS + 1);

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              brg_en;
        logic [DIV_W-1:0]  div;
        logic [GW-1:0]     guard;
    } regs_t;

    regs_t r_d, r_q;

    logic unused_brg_bits;
    assign unused_brg_bits = ^{brg_wdata[0], brg_wdata[BRG_W-2:DIV_W+1]};

    always_comb begin
        r_d = r_q;
        if (mode_we) r_d.mode = mode_wdata;
        if ((r_q.guard != '0) && src_tick) r_d.guard = r_q.guard - 1'b1;
        if (brg_we && (r_q.guard == '0)) begin
            r_d.brg_en = brg_wdata[BRG_EN_BIT];
            r_d.div    = brg_wdata[DIV_W:1];
            r_d.guard  = GW'(GUARD_TICKS);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mode_o       = r_q.mode;
    assign brg_en_o     = r_q.brg_en;
    assign brg_div_o    = r_q.div;
    assign brg_locked_o = (r_q.guard != '0);
endmodule

// File: rtl/uart_bit_timer.sv
module uart_bit_timer #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_tick,
    input  logic             restart,
    input  logic [DIV_W-1:0] restart_val,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (restart) begin
            cnt_d = restart_val;
        end else if (src_tick) begin
            if (cnt_q == '0) begin
                tick  = 1'b1;
                cnt_d = div;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_mode_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_tick,
    input  chan_cfg_t        cfg,
    input  logic             brg_en,
    input  logic [DIV_W-1:0] div,
    input  logic             tx_valid,
    input  logic [7:0]       tx_data,
    output logic             tx_ready,
    output logic             txd
);
    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] frame;
        logic [3:0]         left;
    } tx_t;

    tx_t  s_d, s_q;
    logic start, tick, par;

    assign tx_ready = !s_q.busy && cfg.tx_on && brg_en;
    assign start    = tx_valid && tx_ready;

    uart_bit_timer #(.DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .restart(start),
        .restart_val(div), .div(div), .tick(tick)
    );

    always_comb begin
        s_d = s_q;
        par = 1'b0;
        if (start) begin
            s_d.busy     = 1'b1;
            s_d.frame    = '1;
            s_d.frame[0] = 1'b0;
            for (int i = 0; i < MAX_DATA; i++) begin
                if (i < int'(cfg.data_bits)) begin
                    s_d.frame[1+i] = tx_data[i];
                    par            = par ^ tx_data[i];
                end
            end
            if (cfg.par_en) s_d.frame[1+cfg.data_bits] = cfg.par_even ? par : ~par;
            s_d.left = 4'd2 + cfg.data_bits + {3'b0, cfg.par_en} + {3'b0, cfg.two_stop};
        end else if (s_q.busy && tick) begin
            s_d.frame = {1'b1, s_q.frame[FRAME_W-1:1]};
            s_d.left  = s_q.left - 4'd1;
            if (s_q.left == 4'd1) s_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign txd = s_q.busy ? s_q.frame[0] : 1'b1;
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_mode_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_tick,
    input  chan_cfg_t        cfg,
    input  logic             brg_en,
    input  logic [DIV_W-1:0] div,
    input  logic             rxd,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic             rx_par_err,
    output logic             rx_frm_err,
    output logic             rx_brk
);
    typedef enum logic [1:0] {RX_IDLE, RX_RUN, RX_WAIT_HIGH} rx_state_e;

    typedef struct packed {
        rx_state_e          st;
        logic [FRAME_W-1:0] sh;
        logic [3:0]         idx;
        logic [3:0]         db;
        logic               pe;
        logic               pev;
        logic [7:0]         data;
        logic               valid;
        logic               par_err;
        logic               frm_err;
        logic               brk;
    } rx_t;

    rx_t                s_d, s_q;
    logic               start, tick, par, brk_now;
    logic [FRAME_W-1:0] sh_n;
    logic [3:0]         last_idx;
    logic [7:0]         data_n;

    assign start = (s_q.st == RX_IDLE) && cfg.rx_on && brg_en && !rxd;

    uart_bit_timer #(.DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .restart(start),
        .restart_val(div >> 1), .div(div), .tick(tick)
    );

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        sh_n      = s_q.sh;
        last_idx  = 4'd1 + s_q.db + {3'b0, s_q.pe};
        par       = 1'b0;
        data_n    = '0;
        brk_now   = 1'b0;
        case (s_q.st)
            RX_IDLE: begin
                if (start) begin
                    s_d.st  = RX_RUN;
                    s_d.idx = '0;
                    s_d.sh  = '0;
                    s_d.db  = cfg.data_bits;
                    s_d.pe  = cfg.par_en;
                    s_d.pev = cfg.par_even;
                end
            end
            RX_RUN: begin
                if (tick) begin
                    sh_n[s_q.idx] = rxd;
                    s_d.sh        = sh_n;
                    if ((s_q.idx == '0) && rxd) begin
                        s_d.st = RX_IDLE;          // false start
                    end else if (s_q.idx == last_idx) begin
                        for (int i = 0; i < MAX_DATA; i++) begin
                            if (i < int'(s_q.db)) begin
                                data_n[i] = sh_n[1+i];
                                par       = par ^ sh_n[1+i];
                            end
                        end
                        brk_now     = (sh_n == '0);
                        s_d.data    = data_n;
                        s_d.brk     = brk_now;
                        s_d.frm_err = !rxd && !brk_now;
                        s_d.par_err = s_q.pe && !brk_now &&
                                      (sh_n[1+s_q.db] != (s_q.pev ? par : ~par));
                        s_d.valid   = 1'b1;
                        s_d.st      = brk_now ? RX_WAIT_HIGH : RX_IDLE;
                    end else begin
                        s_d.idx = s_q.idx + 4'd1;
                    end
                end
            end
            RX_WAIT_HIGH: if (rxd) s_d.st = RX_IDLE;
            default:      s_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rx_valid   = s_q.valid;
    assign rx_data    = s_q.data;
    assign rx_par_err = s_q.par_err;
    assign rx_frm_err = s_q.frm_err;
    assign rx_brk     = s_q.brk;
endmodule

// File: rtl/uart_chan_ctrl.sv
module uart_chan_ctrl
    import uart_mode_pkg::*;
#(
    parameter int DIV_W       = 12,
    parameter int GUARD_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_we,
    input  logic [15:0]      mode_wdata,
    input  logic             brg_we,
    input  logic [16:0]      brg_wdata,
    input  logic             brg_src_tick,
    input  logic             tx_valid,
    input  logic [7:0]       tx_data,
    output logic             tx_ready,
    output logic             txd,
    input  logic             rxd,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic             rx_par_err,
    output logic             rx_frm_err,
    output logic             rx_brk,
    output logic [3:0]       chan_data_bits,
    output logic             chan_two_stop,
    output logic             chan_par_en,
    output logic             chan_par_even,
    output logic             chan_tx_on,
    output logic             chan_rx_on,
    output logic             brg_on,
    output logic [DIV_W-1:0] brg_div,
    output logic             brg_locked
);
    logic [MODE_W-1:0] mode_q;
    chan_cfg_t         cfg;

    uart_mode_regs #(.DIV_W(DIV_W), .GUARD_TICKS(GUARD_TICKS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .brg_we(brg_we), .brg_wdata(brg_wdata), .src_tick(brg_src_tick),
        .mode_o(mode_q), .brg_en_o(brg_on), .brg_div_o(brg_div),
        .brg_locked_o(brg_locked)
    );

    assign cfg            = decode_mode(mode_q);
    assign chan_data_bits = cfg.data_bits;
    assign chan_two_stop  = cfg.two_stop;
    assign chan_par_en    = cfg.par_en;
    assign chan_par_even  = cfg.par_even;
    assign chan_tx_on     = cfg.tx_on;
    assign chan_rx_on     = cfg.rx_on;

    uart_tx #(.DIV_W(DIV_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .src_tick(brg_src_tick), .cfg(cfg),
        .brg_en(brg_on), .div(brg_div), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .txd(txd)
    );

    uart_rx #(.DIV_W(DIV_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .src_tick(brg_src_tick), .cfg(cfg),
        .brg_en(brg_on), .div(brg_div), .rxd(rxd),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .rx_brk(rx_brk)
    );
endmodule

// File: rtl/uart_chan_ctrl_chk.sv
module uart_chan_ctrl_chk #(
    parameter int DIV_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             brg_src_tick,
    input logic             tx_ready,
    input logic             txd,
    input logic             rx_valid,
    input logic             rx_par_err,
    input logic             rx_frm_err,
    input logic             rx_brk,
    input logic [3:0]       chan_data_bits,
    input logic             chan_tx_on,
    input logic             brg_on,
    input logic [DIV_W-1:0] brg_div,
    input logic             brg_locked
);
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> txd);                                               // R5
    AST_NO_READY_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_tx_on || !brg_on) |-> !tx_ready);                         // R5
    AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);                                         // R7
    AST_LOCK_FREEZES_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        brg_locked |=> ($stable(brg_div) && $stable(brg_on)));           // R4
    AST_LOCK_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (brg_locked && !brg_src_tick) |=> brg_locked);                   // R4
    AST_BREAK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_brk) |-> (!rx_frm_err && !rx_par_err));          // R10
    AST_LEGAL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        chan_tx_on |-> (chan_data_bits >= 4'd5 && chan_data_bits <= 4'd8)); // R2
endmodule

bind uart_chan_ctrl uart_chan_ctrl_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .brg_src_tick(brg_src_tick),
    .tx_ready(tx_ready), .txd(txd), .rx_valid(rx_valid),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_brk(rx_brk),
    .chan_data_bits(chan_data_bits), .chan_tx_on(chan_tx_on),
    .brg_on(brg_on), .brg_div(brg_div), .brg_locked(brg_locked)
);

// File: tb/tb_uart_chan_ctrl.sv
module tb_uart_chan_ctrl;
    localparam int DIV_W = 12;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic rst_n, mode_we, brg_we, brg_src_tick, tx_valid, rxd;
    logic [15:0] mode_wdata;
    logic [16:0] brg_wdata;
    logic [7:0]  tx_data, rx_data;
    logic tx_ready, txd, rx_valid, rx_par_err, rx_frm_err, rx_brk;
    logic [3:0] chan_data_bits;
    logic chan_two_stop, chan_par_en, chan_par_even, chan_tx_on, chan_rx_on;
    logic brg_on, brg_locked;
    logic [DIV_W-1:0] brg_div;

    uart_chan_ctrl #(.DIV_W(DIV_W), .GUARD_TICKS(2)) dut (.*);

    int checks = 0, errors = 0;
    bit done = 0;

    int mon_cnt = 0;
    logic [7:0] mon_data;
    logic mon_par, mon_frm, mon_brk;
    always @(negedge clk) if (rx_valid === 1'b1) begin
        mon_cnt++; mon_data = rx_data;
        mon_par = rx_par_err; mon_frm = rx_frm_err; mon_brk = rx_brk;
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic logic [15:0] mode_word(input int len_fld, input logic two, pe, ev,
                                              ten, ren, input logic [1:0] op);
        logic [15:0] w = '0;
        w[14:11] = 4'(len_fld); w[10] = two; w[9] = pe; w[8] = ev;
        w[5:4] = op; w[1] = ten; w[0] = ren;
        return w;
    endfunction

    function automatic logic exp_par(input logic [7:0] d, input int db, input logic ev);
        logic p = 1'b0;
        for (int i = 0; i < db; i++) p ^= d[i];
        return ev ? p : ~p;
    endfunction

    function automatic logic [7:0] dmask(input int db);
        return 8'((1 << db) - 1);
    endfunction

    task automatic wr_mode(input logic [15:0] w);
        @(negedge clk); mode_we = 1'b1; mode_wdata = w;
        @(negedge clk); mode_we = 1'b0;
    endtask

    task automatic wr_brg(input logic en, input int div);
        @(negedge clk); brg_we = 1'b1; brg_wdata = '0;
        brg_wdata[16] = en; brg_wdata[DIV_W:1] = DIV_W'(div);
        @(negedge clk); brg_we = 1'b0;
    endtask

    // Bench receiver on txd; samples each bit near its middle.
    task automatic tx_check(input logic [7:0] d, input int db, input logic pe, ev, two,
                            input int p, input logic mid, input logic [15:0] mid_w,
                            input string req);
        logic [7:0] got = '0;
        logic st0, gp = 1'b0, sp = 1'b1;
        int nb = 2 + db + int'(pe) + int'(two);
        while (tx_ready !== 1'b1) @(negedge clk);
        tx_data = d; tx_valid = 1'b1;
        @(negedge clk); tx_valid = 1'b0;
        repeat (p/2 - 1) @(negedge clk);
        st0 = txd;
        for (int i = 1; i < nb; i++) begin
            if (mid && i == 1) begin
                mode_we = 1'b1; mode_wdata = mid_w;
                @(negedge clk); mode_we = 1'b0;
                repeat (p - 1) @(negedge clk);
            end else repeat (p) @(negedge clk);
            if (i <= db) got[i-1] = txd;
            else if (pe && i == db + 1) gp = txd;
            else sp = sp & txd;
        end
        chk({req, " start bit"}, 32'(st0), 0);
        chk({req, " data"}, 32'(got), 32'(d & dmask(db)));
        if (pe) chk({req, " parity bit"}, 32'(gp), 32'(exp_par(d, db, ev)));
        chk({req, " stop bits"}, 32'(sp), 1);
        repeat (p) @(negedge clk);
        chk({req, " idle line"}, 32'(txd), 1);
    endtask

    // Bench transmitter on rxd.
    task automatic rx_send(input logic [7:0] d, input int db, input logic pe, ev, two,
                           input logic flip_par, bad_stop, brk, input int p);
        logic [11:0] f = '1;
        int nb = 2 + db + int'(pe) + int'(two);
        f[0] = 1'b0;
        for (int i = 0; i < db; i++) f[1+i] = d[i];
        if (pe) f[1+db] = exp_par(d, db, ev) ^ flip_par;
        if (bad_stop) f[1+db+int'(pe)] = 1'b0;
        if (brk) f = '0;
        for (int i = 0; i < nb; i++) begin rxd = f[i]; repeat (p) @(negedge clk); end
        rxd = 1'b1;
        repeat (p + 2) @(negedge clk);
    endtask

    task automatic rx_expect(input int base, input logic [7:0] d, input logic pe_err, fe, bk,
                             input string req);
        chk({req, " rx count"}, 32'(mon_cnt), 32'(base + 1));
        chk({req, " rx data"}, 32'(mon_data), 32'(d));
        chk({req, " rx parity flag"}, 32'(mon_par), 32'(pe_err));
        chk({req, " rx framing flag"}, 32'(mon_frm), 32'(fe));
        chk({req, " rx break flag"}, 32'(mon_brk), 32'(bk));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        int divs[5] = '{3, 5, 7, 9, 15};
        void'($urandom(32'd20240611));
        rst_n = 1'b0; mode_we = 0; brg_we = 0; brg_src_tick = 1'b1; tx_valid = 0;
        rxd = 1'b1; mode_wdata = '0; brg_wdata = '0; tx_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 txd", 32'(txd), 1);
        chk("R1 tx_ready", 32'(tx_ready), 0);
        chk("R1 enables", 32'({chan_tx_on, chan_rx_on, brg_on, brg_locked, rx_valid}), 0);
        chk("R1 data bits", 32'(chan_data_bits), 0);
        chk("R1 divisor", 32'(brg_div), 0);

        // R2 mode decoding
        wr_mode(mode_word(9, 1, 1, 1, 1, 1, 2'd2));
        chk("R2 legal decode", 32'({chan_data_bits, chan_two_stop, chan_par_en, chan_par_even,
                                    chan_tx_on, chan_rx_on}), 32'({4'd8, 5'b11111}));
        wr_mode(mode_word(6, 0, 0, 0, 1, 0, 2'd2));
        chk("R2 five bits odd", 32'({chan_data_bits, chan_two_stop, chan_par_en, chan_par_even,
                                     chan_tx_on, chan_rx_on}), 32'({4'd5, 5'b00010}));
        wr_mode(mode_word(7, 0, 0, 0, 1, 1, 2'd1));
        chk("R2 wrong op mode", 32'({chan_data_bits, chan_tx_on, chan_rx_on}), 0);
        wr_mode(mode_word(5, 0, 0, 0, 1, 1, 2'd2));
        chk("R2 length too short", 32'({chan_data_bits, chan_tx_on, chan_rx_on}), 0);
        wr_mode(mode_word(10, 0, 0, 0, 1, 1, 2'd2));
        chk("R2 length too long", 32'({chan_data_bits, chan_tx_on, chan_rx_on}), 0);
        wr_mode(mode_word(8, 0, 0, 0, 0, 0, 2'd2));
        chk("R2 channel off", 32'({chan_data_bits, chan_tx_on, chan_rx_on}), 32'({4'd7, 2'b00}));

        // R3 / R4 bit-rate register and guard
        brg_src_tick = 1'b0;
        wr_brg(1'b1, 7);
        chk("R3 enable and divisor", 32'({brg_on, brg_div}), 32'({1'b1, 12'd7}));
        chk("R4 locked after write", 32'(brg_locked), 1);
        wr_brg(1'b1, 3);
        chk("R4 write ignored while locked", 32'(brg_div), 7);
        @(negedge clk); brg_src_tick = 1'b1; @(negedge clk); brg_src_tick = 1'b0;
        chk("R4 locked after one tick", 32'(brg_locked), 1);
        wr_brg(1'b0, 3);
        chk("R4 still ignored", 32'({brg_on, brg_div}), 32'({1'b1, 12'd7}));
        @(negedge clk); brg_src_tick = 1'b1; @(negedge clk); brg_src_tick = 1'b0;
        chk("R4 unlocked after two ticks", 32'(brg_locked), 0);
        wr_brg(1'b1, 3);
        chk("R4 accepted after release", 32'(brg_div), 3);
        brg_src_tick = 1'b1;
        repeat (3) @(negedge clk);

        // R5 ready needs the generator enabled
        wr_mode(mode_word(9, 0, 0, 0, 1, 1, 2'd2));
        wr_brg(1'b0, 3);
        @(negedge clk);
        chk("R5 no ready with generator off", 32'(tx_ready), 0);
        repeat (3) @(negedge clk);
        wr_brg(1'b1, 7);
        repeat (3) @(negedge clk);
        chk("R5 ready when enabled and idle", 32'(tx_ready), 1);

        // R5 directed frames: 8 data, even parity, two stops; 5 data, odd parity
        wr_mode(mode_word(9, 1, 1, 1, 1, 1, 2'd2));
        tx_check(8'hA5, 8, 1, 1, 1, 8, 0, '0, "R5 8E2");
        wr_mode(mode_word(6, 0, 1, 0, 1, 1, 2'd2));
        tx_check(8'hF3, 5, 1, 0, 0, 8, 0, '0, "R5 5O1");

        // R6 mode rewrite during a frame
        wr_mode(mode_word(9, 0, 1, 1, 1, 1, 2'd2));
        tx_check(8'h3C, 8, 1, 1, 0, 8, 1, mode_word(6, 1, 0, 0, 0, 0, 2'd2), "R6 mid-frame rewrite");

        // R7 / R8 / R9 / R10 receive corners
        wr_mode(mode_word(9, 0, 1, 1, 1, 1, 2'd2));
        base = mon_cnt; rx_send(8'h96, 8, 1, 1, 0, 0, 0, 0, 8);
        rx_expect(base, 8'h96, 0, 0, 0, "R7 clean frame");
        base = mon_cnt; rx_send(8'h96, 8, 1, 1, 0, 1, 0, 0, 8);
        rx_expect(base, 8'h96, 1, 0, 0, "R8 parity mismatch");
        base = mon_cnt; rx_send(8'h5A, 8, 1, 1, 0, 0, 1, 0, 8);
        rx_expect(base, 8'h5A, 0, 1, 0, "R9 low stop bit");
        base = mon_cnt; rx_send(8'h00, 8, 1, 1, 0, 0, 0, 1, 8);
        rx_expect(base, 8'h00, 0, 0, 1, "R10 break");
        base = mon_cnt; rx_send(8'h41, 8, 1, 1, 0, 0, 0, 0, 8);
        rx_expect(base, 8'h41, 0, 0, 0, "R10 rearm after break");
        wr_mode(mode_word(7, 0, 0, 0, 1, 1, 2'd2));
        base = mon_cnt; rx_send(8'hFF, 6, 0, 0, 0, 0, 0, 0, 8);
        rx_expect(base, 8'h3F, 0, 0, 0, "R7 upper bits zero");

        // R11 receiver disabled
        wr_mode(mode_word(9, 0, 0, 0, 1, 0, 2'd2));
        base = mon_cnt; rx_send(8'h12, 8, 0, 0, 0, 0, 0, 0, 8);
        chk("R11 no rx_valid when off", 32'(mon_cnt), 32'(base));

        // Random frames through both directions (R3 R5 R7)
        for (int n = 0; n < 30; n++) begin
            int db = 5 + int'($urandom_range(3));
            logic pe = 1'($urandom), ev = 1'($urandom), two = 1'($urandom);
            int dv = divs[$urandom_range(4)];
            logic [7:0] d = 8'($urandom);
            wr_brg(1'b1, dv);
            repeat (3) @(negedge clk);
            wr_mode(mode_word(db + 1, two, pe, ev, 1, 1, 2'd2));
            tx_check(d, db, pe, ev, two, dv + 1, 0, '0, "R3 R5 random tx");
            d = 8'($urandom);
            base = mon_cnt; rx_send(d, db, pe, ev, two, 0, 0, 0, dv + 1);
            rx_expect(base, d & dmask(db), 0, 0, 0, "R7 random rx");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule